// File: doc/BRIEF.md
# Single-Cycle 16-bit Harvard Processor Core

This block is a compact processor that fetches and completes one 16-bit instruction on every clock. Instructions and data live in two separate word-addressed memories whose depths are parameters. An eight-entry register file of 16-bit words feeds a function unit through two read ports. The second operand is either a register or a small constant taken from the instruction, and the value written back is either the function-unit result or a word read from data memory. A combinational decoder turns the 7-bit opcode into the steering signals, and a separate program-counter unit chooses between counting up, a relative branch and an absolute jump.

Both memories are filled through a loader port while reset is held. Once reset falls, the core runs from address 0. Every register or memory write it makes is shown on commit outputs in the same cycle, so a testbench can follow the program without looking inside. The N and Z flags come from the current function-unit result and are not stored.

Top module: `sc16_core`

## Requirements
- R1: While `rst` is 1, the PC is cleared to 0 at the clock edge, `rf_we_o` and `dm_we_o` are 0, and the loader writes instruction memory (`ld_imem_we`) or data memory (`ld_dmem_we`) at `ld_addr` modulo the memory depth.
- R2: Any instruction that is not a taken branch or a jump advances the PC by exactly 1 at the next clock edge.
- R3: An instruction word splits into opcode [15:9], destination DR [8:6], source A SA [5:3] and source B SB [2:0]. These register-operand opcodes write their result to R[DR]: MOVA 0000000 (A), INC 0000001 (A+1), ADD 0000010 (A+B), AND 0001000, OR 0001001, XOR 0001010, NOT 0001011 (~A), MOVB 0001100 (B).
- R4: SUB 0000101 writes A + ~B + 1 and DEC 0000110 writes A − 1, both modulo 2^16.
- R5: SHR 0001101 and SHL 0001110 shift R[SB] (not R[SA]) by one place, logically, filling with 0.
- R6: LDI 1001100 writes the 3-bit field [2:0], zero-extended, to R[DR]. ADI 1000010 writes R[SA] plus that zero-extended value.
- R7: LD 0010000 writes to R[DR] the data-memory word at address R[SA] (modulo the depth). `dm_addr_o` shows R[SA].
- R8: ST 0100000 writes R[SB] to data memory at R[SA] and writes no register.
- R9: BRZ 1100000 loads PC + sign-extended {IR[8:6], IR[2:0]} when R[SA] is zero, and otherwise loads PC + 1. It writes nothing.
- R10: BRN 1100001 takes the same branch when bit 15 of R[SA] is 1, and otherwise loads PC + 1. It writes nothing.
- R11: JMP 1110000 loads R[SA] into the PC and writes nothing.
- R12: `flag_n_o` is bit 15 of the function-unit result and `flag_z_o` is 1 when that result is zero. For branches and jumps the result is R[SA] passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; loader is active only while it is high |
| ld_imem_we | input | 1 | Loader write strobe for instruction memory |
| ld_dmem_we | input | 1 | Loader write strobe for data memory |
| ld_addr | input | 16 | Loader word address |
| ld_data | input | 16 | Loader write word |
| pc_o | output | 16 | Address of the instruction now executing |
| instr_o | output | 16 | Instruction now executing |
| rf_we_o | output | 1 | Register write at the coming edge |
| rf_waddr_o | output | 3 | Destination register of that write |
| rf_wdata_o | output | 16 | Value of that write |
| dm_we_o | output | 1 | Data-memory write at the coming edge |
| dm_addr_o | output | 16 | Data-memory address (R[SA]) |
| dm_wdata_o | output | 16 | Data-memory write word (R[SB]) |
| flag_n_o | output | 1 | Sign of the function-unit result |
| flag_z_o | output | 1 | Function-unit result is zero |

## Verification
Each instruction's commit outputs and flags are valid in the cycle the instruction sits at `pc_o`, and its effect on registers, data memory and the PC appears at the next rising edge. The bench's behavioural model therefore compares the commit outputs and flags half a cycle into each instruction's cycle, against the state the model holds for that instruction. It then advances the model by one instruction, and the PC check at the next sample covers the sequencing. Reset is checked one edge after it is raised, because the PC clears only at that edge.

// File: rtl/sc16_pkg.sv
package sc16_pkg;
  localparam int WORD_W = 16;
  localparam int REG_AW = 3;

  typedef struct packed {
    logic       mb;   // operand B from immediate
    logic       md;   // write-back from data memory
    logic       rw;   // register write
    logic       mw;   // data-memory write
    logic       pl;   // PC load (branch or jump)
    logic       jb;   // jump when 1, branch when 0
    logic       bc;   // branch on N when 1, on Z when 0
    logic [3:0] fs;   // function select
  } ctrl_t;

  localparam logic [3:0] FS_PASS_A = 4'b0000;
  localparam logic [3:0] FS_INC    = 4'b0001;
  localparam logic [3:0] FS_ADD    = 4'b0010;
  localparam logic [3:0] FS_ADD1   = 4'b0011;
  localparam logic [3:0] FS_ADDNB  = 4'b0100;
  localparam logic [3:0] FS_SUB    = 4'b0101;
  localparam logic [3:0] FS_DEC    = 4'b0110;
  localparam logic [3:0] FS_PASS_2 = 4'b0111;
  localparam logic [3:0] FS_AND    = 4'b1000;
  localparam logic [3:0] FS_OR     = 4'b1001;
  localparam logic [3:0] FS_XOR    = 4'b1010;
  localparam logic [3:0] FS_NOT    = 4'b1011;
  localparam logic [3:0] FS_PASS_B = 4'b1100;
  localparam logic [3:0] FS_SHR    = 4'b1101;
  localparam logic [3:0] FS_SHL    = 4'b1110;
endpackage

// File: rtl/sc16_decode.sv
module sc16_decode
  import sc16_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [15:0]     instr,
  output ctrl_t           ctrl,
  output logic [2:0]      dr,
  output logic [2:0]      sa,
  output logic [2:0]      sb,
  output logic [DW-1:0]   imm,
  output logic [DW-1:0]   offs
);
  localparam int IMM_W = 3;
  localparam int OFF_W = 6;

  logic [OFF_W-1:0] ad;

  always_comb begin
    ctrl.mb = instr[15];
    ctrl.md = instr[13];
    ctrl.rw = ~instr[14];
    ctrl.mw = ~instr[15] & instr[14];
    ctrl.pl = instr[15] & instr[14];
    ctrl.jb = instr[13];
    ctrl.bc = instr[9];
    // the condition bit is masked off so branches and jumps pass A through
    ctrl.fs = {instr[12:10], instr[9] & ~(instr[15] & instr[14])};
  end

  assign dr   = instr[8:6];
  assign sa   = instr[5:3];
  assign sb   = instr[2:0];
  assign imm  = {{(DW-IMM_W){1'b0}}, instr[2:0]};
  assign ad   = {instr[8:6], instr[2:0]};
  assign offs = {{(DW-OFF_W){ad[OFF_W-1]}}, ad};
endmodule

// File: rtl/sc16_func_unit.sv
module sc16_func_unit
  import sc16_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [3:0]    fs,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] f
);
  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    unique case (fs)
      FS_PASS_A: f = a;
      FS_INC:    f = a + ONE;
      FS_ADD:    f = a + b;
      FS_ADD1:   f = a + b + ONE;
      FS_ADDNB:  f = a + ~b;
      FS_SUB:    f = a + ~b + ONE;
      FS_DEC:    f = a - ONE;
      FS_PASS_2: f = a;
      FS_AND:    f = a & b;
      FS_OR:     f = a | b;
      FS_XOR:    f = a ^ b;
      FS_NOT:    f = ~a;
      FS_PASS_B: f = b;
      FS_SHR:    f = {1'b0, b[DW-1:1]};
      FS_SHL:    f = {b[DW-2:0], 1'b0};
      default:   f = b;
    endcase
  end
endmodule

// File: rtl/sc16_pc.sv
module sc16_pc #(
  parameter int PCW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pl,
  input  logic           jb,
  input  logic           bc,
  input  logic           n,
  input  logic           z,
  input  logic [PCW-1:0] jaddr,
  input  logic [PCW-1:0] offs,
  output logic [PCW-1:0] pc
);
  localparam logic [PCW-1:0] STEP = PCW'(1);

  logic           take_br;
  logic [PCW-1:0] pc_nxt;

  always_comb begin
    take_br = bc ? n : z;
    if (pl && jb)           pc_nxt = jaddr;
    else if (pl && take_br) pc_nxt = pc + offs;
    else                    pc_nxt = pc + STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_nxt;
  end

  assert_count_up_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pl)) |-> (pc == $past(pc) + STEP));

  assert_jump_target_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pl) && $past(jb)) |-> (pc == $past(jaddr)));
endmodule

// File: rtl/sc16_regfile.sv
module sc16_regfile #(
  parameter int DW    = 16,
  parameter int NREGS = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(NREGS)-1:0] raddr_a,
  input  logic [$clog2(NREGS)-1:0] raddr_b,
  output logic [DW-1:0]            rdata_a,
  output logic [DW-1:0]            rdata_b
);
  logic [DW-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wdata;
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/sc16_core.sv
module sc16_core
  import sc16_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ld_imem_we,
  input  logic        ld_dmem_we,
  input  logic [15:0] ld_addr,
  input  logic [15:0] ld_data,
  output logic [15:0] pc_o,
  output logic [15:0] instr_o,
  output logic        rf_we_o,
  output logic [2:0]  rf_waddr_o,
  output logic [15:0] rf_wdata_o,
  output logic        dm_we_o,
  output logic [15:0] dm_addr_o,
  output logic [15:0] dm_wdata_o,
  output logic        flag_n_o,
  output logic        flag_z_o
);
  localparam int DW    = WORD_W;
  localparam int NREGS = 1 << REG_AW;
  localparam int IAW   = $clog2(IMEM_DEPTH);
  localparam int DAW   = $clog2(DMEM_DEPTH);

  logic [DW-1:0] imem [IMEM_DEPTH];
  logic [DW-1:0] dmem [DMEM_DEPTH];

  logic [DW-1:0] pc, instr, bus_a, bus_b, reg_b, imm, offs, fu_f, dm_rdata, wb_data;
  logic [2:0]    dr, sa, sb;
  ctrl_t         ctrl;
  logic          n_flag, z_flag, rf_we, dm_we;

  // instruction memory: loader write, asynchronous fetch
  always_ff @(posedge clk) begin
    if (rst && ld_imem_we) imem[ld_addr[IAW-1:0]] <= ld_data;
  end
  assign instr = imem[pc[IAW-1:0]];

  sc16_decode #(.DW(DW)) u_dec (
    .instr (instr),
    .ctrl  (ctrl),
    .dr    (dr),
    .sa    (sa),
    .sb    (sb),
    .imm   (imm),
    .offs  (offs)
  );

  assign rf_we = ctrl.rw & ~rst;
  assign dm_we = ctrl.mw & ~rst;

  sc16_regfile #(.DW(DW), .NREGS(NREGS)) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (dr),
    .wdata   (wb_data),
    .raddr_a (sa),
    .raddr_b (sb),
    .rdata_a (bus_a),
    .rdata_b (reg_b)
  );

  assign bus_b = ctrl.mb ? imm : reg_b;

  sc16_func_unit #(.DW(DW)) u_fu (
    .fs (ctrl.fs),
    .a  (bus_a),
    .b  (bus_b),
    .f  (fu_f)
  );

  assign n_flag = fu_f[DW-1];
  assign z_flag = (fu_f == '0);

  // data memory: one write port shared by the loader and the store path
  always_ff @(posedge clk) begin
    if (rst && ld_dmem_we) dmem[ld_addr[DAW-1:0]] <= ld_data;
    else if (dm_we)        dmem[bus_a[DAW-1:0]]   <= bus_b;
  end
  assign dm_rdata = dmem[bus_a[DAW-1:0]];

  assign wb_data = ctrl.md ? dm_rdata : fu_f;

  sc16_pc #(.PCW(DW)) u_pc (
    .clk   (clk),
    .rst   (rst),
    .pl    (ctrl.pl),
    .jb    (ctrl.jb),
    .bc    (ctrl.bc),
    .n     (n_flag),
    .z     (z_flag),
    .jaddr (bus_a),
    .offs  (offs),
    .pc    (pc)
  );

  assign pc_o       = pc;
  assign instr_o    = instr;
  assign rf_we_o    = rf_we;
  assign rf_waddr_o = dr;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = dm_we;
  assign dm_addr_o  = bus_a;
  assign dm_wdata_o = bus_b;
  assign flag_n_o   = n_flag;
  assign flag_z_o   = z_flag;

  assert_branch_passes_a_R12: assert property (@(posedge clk) disable iff (rst)
    (instr[15:14] == 2'b11) |-> (fu_f == bus_a));

  assert_imm_zero_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (instr[15] && !instr[14]) |-> (bus_b == {{(DW-3){1'b0}}, instr[2:0]}));

  assert_store_no_rf_write_R8: assert property (@(posedge clk) disable iff (rst)
    dm_we_o |-> (!rf_we_o && dm_wdata_o == reg_b));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |-> (!rf_we_o && !dm_we_o));
endmodule

// File: tb/sc16_core_test.sv
module sc16_core_test;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_imem_we = 1'b0, ld_dmem_we = 1'b0;
  logic [15:0] ld_addr = '0, ld_data = '0;
  logic [15:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic [2:0]  rf_waddr_o;
  logic        rf_we_o, dm_we_o, flag_n_o, flag_z_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sc16_core #(.IMEM_DEPTH(DEPTH), .DMEM_DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o), .instr_o(instr_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o),
    .flag_n_o(flag_n_o), .flag_z_o(flag_z_o)
  );

  // reference state
  logic [15:0] mi [DEPTH];
  logic [15:0] md [DEPTH];
  logic [15:0] mr [8];
  logic [15:0] mpc;

  localparam logic [6:0] OP_MOVA = 7'b0000000, OP_INC = 7'b0000001, OP_ADD = 7'b0000010,
    OP_SUB = 7'b0000101, OP_DEC = 7'b0000110, OP_AND = 7'b0001000, OP_OR = 7'b0001001,
    OP_XOR = 7'b0001010, OP_NOT = 7'b0001011, OP_MOVB = 7'b0001100, OP_SHR = 7'b0001101,
    OP_SHL = 7'b0001110, OP_LDI = 7'b1001100, OP_ADI = 7'b1000010, OP_LD = 7'b0010000,
    OP_ST = 7'b0100000, OP_BRZ = 7'b1100000, OP_BRN = 7'b1100001, OP_JMP = 7'b1110000;

  function automatic logic [15:0] rr(logic [6:0] op, int d, int a, int b);
    return {op, 3'(d), 3'(a), 3'(b)};
  endfunction

  function automatic logic [15:0] br(logic [6:0] op, int a, int off);
    logic [5:0] ad = 6'(off);
    return {op, ad[5:3], 3'(a), ad[2:0]};
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at pc %0d: actual %h expected %h", req, what, mpc, act, exp);
    end
  endtask

  // compare the current cycle's outputs with the model, then advance the model
  task automatic step_model();
    logic [15:0] ins, a, b, imm, res, npc, offs;
    logic [6:0]  op;
    logic        wr, st, fl;
    string       tag;
    ins  = mi[mpc[5:0]];
    op   = ins[15:9];
    a    = mr[ins[5:3]];
    b    = mr[ins[2:0]];
    imm  = {13'd0, ins[2:0]};
    offs = {{10{ins[8]}}, ins[8:6], ins[2:0]};
    wr = 1'b1; st = 1'b0; fl = 1'b1; res = a; npc = mpc + 16'd1;
    case (op)
      OP_MOVA: begin res = a;         tag = "R3";  end
      OP_INC:  begin res = a + 16'd1; tag = "R3";  end
      OP_ADD:  begin res = a + b;     tag = "R3";  end
      OP_AND:  begin res = a & b;     tag = "R3";  end
      OP_OR:   begin res = a | b;     tag = "R3";  end
      OP_XOR:  begin res = a ^ b;     tag = "R3";  end
      OP_NOT:  begin res = ~a;        tag = "R3";  end
      OP_MOVB: begin res = b;         tag = "R3";  end
      OP_SUB:  begin res = a - b;     tag = "R4";  end
      OP_DEC:  begin res = a - 16'd1; tag = "R4";  end
      OP_SHR:  begin res = b >> 1;    tag = "R5";  end
      OP_SHL:  begin res = b << 1;    tag = "R5";  end
      OP_LDI:  begin res = imm;       tag = "R6";  end
      OP_ADI:  begin res = a + imm;   tag = "R6";  end
      OP_LD:   begin res = md[a[5:0]]; fl = 1'b0; tag = "R7"; end
      OP_ST:   begin wr = 1'b0; st = 1'b1; fl = 1'b0; tag = "R8"; end
      OP_BRZ:  begin wr = 1'b0; tag = "R9";  if (a == 16'd0) npc = mpc + offs; end
      OP_BRN:  begin wr = 1'b0; tag = "R10"; if (a[15]) npc = mpc + offs; end
      OP_JMP:  begin wr = 1'b0; tag = "R11"; npc = a; end
      default: begin wr = 1'b0; fl = 1'b0; tag = "R3"; end
    endcase
    check("R2", "pc", pc_o, mpc);
    check(tag, "rf_we", {15'd0, rf_we_o}, {15'd0, wr});
    if (wr) begin
      check(tag, "rf_waddr", {13'd0, rf_waddr_o}, {13'd0, ins[8:6]});
      check(tag, "rf_wdata", rf_wdata_o, res);
    end
    check(tag, "dm_we", {15'd0, dm_we_o}, {15'd0, st});
    if (op == OP_LD || st) check(tag, "dm_addr", dm_addr_o, a);
    if (st) check(tag, "dm_wdata", dm_wdata_o, b);
    if (fl) begin
      check("R12", "flag_n", {15'd0, flag_n_o}, {15'd0, res[15]});
      check("R12", "flag_z", {15'd0, flag_z_o}, {15'd0, res == 16'd0});
    end
    if (wr) mr[ins[8:6]] = res;
    if (st) md[a[5:0]] = b;
    mpc = npc;
  endtask

  task automatic check_reset_state();
    check("R1", "pc in reset", pc_o, 16'd0);
    check("R1", "rf_we in reset", {15'd0, rf_we_o}, 16'd0);
    check("R1", "dm_we in reset", {15'd0, dm_we_o}, 16'd0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mi[i] = 16'd0; md[i] = 16'd0; end
    for (int r = 0; r < 8; r++) mi[r] = rr(OP_LDI, r, 0, (r * 5 + 1) % 8);
    mi[8]  = rr(OP_ADD, 3, 1, 2);
    mi[9]  = rr(OP_SUB, 4, 2, 1);
    mi[10] = rr(OP_SUB, 5, 1, 1);
    mi[11] = rr(OP_INC, 6, 4, 0);
    mi[12] = rr(OP_DEC, 7, 5, 0);
    mi[13] = rr(OP_AND, 0, 1, 2);
    mi[14] = rr(OP_OR,  0, 1, 2);
    mi[15] = rr(OP_XOR, 0, 1, 2);
    mi[16] = rr(OP_NOT, 0, 1, 0);
    mi[17] = rr(OP_MOVA, 2, 4, 0);
    mi[18] = rr(OP_MOVB, 0, 0, 2);
    mi[19] = rr(OP_SHR, 0, 0, 2);
    mi[20] = rr(OP_SHL, 0, 0, 2);
    mi[21] = rr(OP_ADI, 3, 3, 7);
    mi[22] = rr(OP_ST,  0, 1, 3);
    mi[23] = rr(OP_LD,  0, 1, 0);
    mi[24] = rr(OP_LD,  4, 4, 0);
    mi[25] = br(OP_BRZ, 5, 3);
    mi[26] = rr(OP_LDI, 7, 0, 7);
    mi[27] = rr(OP_LDI, 7, 0, 7);
    mi[28] = br(OP_BRZ, 1, 10);
    mi[29] = br(OP_BRN, 6, 2);
    mi[30] = rr(OP_LDI, 7, 0, 7);
    mi[31] = br(OP_BRN, 1, 20);
    mi[32] = rr(OP_LDI, 7, 0, 5);
    mi[33] = rr(OP_SHL, 7, 0, 7);
    mi[34] = rr(OP_SHL, 7, 0, 7);
    mi[35] = rr(OP_SHL, 7, 0, 7);
    mi[36] = rr(OP_JMP, 0, 7, 0);
    mi[40] = rr(OP_ADI, 0, 0, 1);
    mi[41] = br(OP_BRN, 6, -1);
    md[62] = 16'h1234;
    md[5]  = 16'h00c0;
    for (int r = 0; r < 8; r++) mr[r] = 16'd0;
    mpc = 16'd0;

    // load both memories while reset holds the core (R1)
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      ld_imem_we = 1'b1; ld_addr = 16'(i); ld_data = mi[i];
      @(negedge clk);
    end
    ld_imem_we = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      ld_dmem_we = 1'b1; ld_addr = 16'(i + DEPTH); ld_data = md[i];
      @(negedge clk);
    end
    ld_dmem_we = 1'b0;
    #1 check_reset_state();
    @(negedge clk);
    rst = 1'b0;

    for (int c = 0; c < 90; c++) begin
      #1 step_model();
      @(negedge clk);
    end

    // reset in the middle of the loop: PC returns to 0, registers keep values
    rst = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #1 check_reset_state();
    end
    mpc = 16'd0;
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 70; c++) begin
      #1 step_model();
      @(negedge clk);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule